// File: doc/BRIEF.md
# Spread-Spectrum Triangle Modulation Generator

This block produces the digital frequency-offset profile for a fractional-N feedback divider. It runs from the reference clock and sweeps a signed offset word along a triangle. The PLL output frequency therefore moves back and forth across a small band, which spreads its energy and lowers peak emissions. The offset is added downstream to the nominal divide word. A turnaround flag marks every cycle in which the sweep sits at one of its two extremes. Noise shaping, the VCO and the loop itself live outside this block.

Two profiles are offered. The symmetric profile swings equally above and below the target, so the average equals the target. The one-sided profile never goes above the target and spends its whole swing below it. A depth code picks the span as a power-of-two multiple of a base unit. A rate select picks a slow sweep near 32 kHz or a fast sweep near 120 kHz. The step per reference cycle is derived with an exact remainder accumulator, so both endpoints are reached exactly at the end of each half period. All outputs of a shared generator carry the same deviation and rate.

Top module: `ssc_mod_gen`

## Requirements
- R1: While rst_n is low at a clock edge, offset_o is 0 and turn_o is 0 after that edge, whatever the other inputs are.
- R2: If en_i is low at a clock edge, offset_o is 0 and turn_o is 0 after that edge.
- R3: In center mode (mode_i = 0), the first edge with en_i high after it was low gives offset_o = 0, and the edge after that gives offset_o > 0.
- R4: In center mode, with A = UNIT_LSB << code, the offset stays within [-A, +A] and reaches both -A and +A in every period.
- R5: In down mode (mode_i = 1), the sweep starts at offset 0 with turn_o = 1 and then falls. The offset stays within [-2A, 0] and reaches both ends.
- R6: Depth codes above 4 (depth_i is 3 bits) behave exactly as code 4.
- R7: With rate_i = 0 for slow and 1 for fast, each half period lasts H = 2*floor(floor(REF_HZ/rate_hz)/4) cycles. These are 390 and 104 cycles for the defaults (25 MHz reference, 32 kHz and 120 kHz), so consecutive turn_o pulses are H cycles apart.
- R8: Each extreme is held for exactly one cycle, and turn_o is 1 in exactly those cycles. At half-period step t of H, the offset equals floor(S*t/H) - base. Here S = 2A, base = A in center mode and S in down mode, and t counts up to H and then back down to 0.
- R9: mode_i, depth_i and rate_i are sampled only on the edge that starts a sweep. Changing them while en_i stays high has no effect on offset_o.
- R10: While running, the offset changes by at most floor(S/H)+1 per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Sweep enable; a rising level starts a new sweep |
| mode_i | input | 1 | 0 = center spread, 1 = down spread |
| depth_i | input | 3 | Spread depth code (0..4, higher saturates) |
| rate_i | input | 1 | 0 = slow sweep, 1 = fast sweep |
| offset_o | output | OFS_W (16) | Signed offset to add to the divide word |
| turn_o | output | 1 | High while the sweep sits at an extreme |

## Verification
Every result is registered, so offset_o and turn_o reflect the inputs sampled at one rising edge, right after that edge. An enable edge therefore gives the start value one edge later and the first step two edges later. A disable gives zero one edge later. The bench keeps a behavioural model that applies the same one-edge latency. It compares both outputs against that model at every falling edge, midway between the edges where the outputs settle. The directed checks for start values, extremes and turnaround spacing are sampled at those same falling edges, counted from the edge where the stimulus first becomes visible.

// File: rtl/ssc_pkg.sv
// Shared types and elaboration-time helpers for the spread-spectrum
// modulation generator. Assumes integer reference and rate frequencies.
package ssc_pkg;

    localparam int DEPTH_W = 3;

    typedef enum logic {
        SPREAD_CENTER = 1'b0,
        SPREAD_DOWN   = 1'b1
    } spread_mode_e;

    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } sweep_rate_e;

    typedef struct packed {
        spread_mode_e         mode;
        sweep_rate_e          rate;
        logic [DEPTH_W-1:0]   depth;
    } sweep_cfg_t;

    // Half-period length in reference cycles, forced even so that the
    // center profile can start exactly at mid-span.
    function automatic int half_cycles(input int ref_hz, input int rate_hz);
        return ((ref_hz / rate_hz) / 4) * 2;
    endfunction

    // Full peak-to-peak span in offset LSBs for a depth code.
    function automatic int full_span(input int unit_lsb, input int code);
        return (2 * unit_lsb) << code;
    endfunction

endpackage

// File: rtl/ssc_cfg_hold.sv
// Configuration capture. The mode, rate and depth are taken only on the
// edge that starts a sweep, with the depth code saturated to the highest
// legal code. While running, the captured copy drives the datapath.
// Assumes en_i is synchronous to clk.
module ssc_cfg_hold
    import ssc_pkg::*;
#(
    parameter int MAX_CODE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  sweep_cfg_t cfg_i,
    output sweep_cfg_t cfg_eff_o,
    output logic       start_o,
    output logic       run_o
);

    localparam logic [DEPTH_W-1:0] MAX_CODE_L = DEPTH_W'(MAX_CODE);

    sweep_cfg_t cfg_q;
    sweep_cfg_t cfg_sat;
    logic       run_q;

    // Saturate the depth code of the incoming configuration.
    always_comb begin
        cfg_sat = cfg_i;
        if (cfg_i.depth > MAX_CODE_L) begin
            cfg_sat.depth = MAX_CODE_L;
        end
    end

    // Start strobe and the configuration the datapath uses this cycle.
    always_comb begin
        start_o   = en_i && !run_q;
        cfg_eff_o = start_o ? cfg_sat : cfg_q;
    end

    // Running flag and captured configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cfg_q <= '0;
        end else begin
            run_q <= en_i;
            if (en_i && !run_q) begin
                cfg_q <= cfg_sat;
            end
        end
    end

    assign run_o = run_q;

endmodule

// File: rtl/ssc_step_table.sv
// Elaboration-time step table. For each sweep rate and depth code it holds
// the half period H, the span S, and the integer quotient and remainder of
// S/H. The sweep core uses these to walk the span exactly in H cycles.
// Assumes the depth code on cfg_i is already saturated below NUM_CODES.
module ssc_step_table
    import ssc_pkg::*;
#(
    parameter int REF_HZ       = 25_000_000,
    parameter int RATE_SLOW_HZ = 32_000,
    parameter int RATE_FAST_HZ = 120_000,
    parameter int UNIT_LSB     = 256,
    parameter int NUM_CODES    = 5,
    parameter int P_W          = 14,
    parameter int T_W          = 9
) (
    input  sweep_cfg_t     cfg_i,
    output logic [P_W-1:0] span_o,
    output logic [P_W-1:0] step_q_o,
    output logic [T_W-1:0] step_r_o,
    output logic [T_W-1:0] half_o
);

    logic [P_W-1:0] span_tab [NUM_CODES];
    logic [T_W-1:0] half_tab [2];
    logic [P_W-1:0] q_tab    [2][NUM_CODES];
    logic [T_W-1:0] r_tab    [2][NUM_CODES];

    for (genvar rt = 0; rt < 2; rt++) begin : g_rate
        localparam int HLEN = half_cycles(REF_HZ, (rt == 0) ? RATE_SLOW_HZ : RATE_FAST_HZ);
        assign half_tab[rt] = T_W'(HLEN);
        for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
            localparam int SPAN = full_span(UNIT_LSB, c);
            assign q_tab[rt][c] = P_W'(SPAN / HLEN);
            assign r_tab[rt][c] = T_W'(SPAN % HLEN);
            if (rt == 0) begin : g_span
                assign span_tab[c] = P_W'(SPAN);
            end
        end
    end

    // Select the entry for the active configuration.
    always_comb begin
        span_o   = span_tab[cfg_i.depth];
        half_o   = half_tab[cfg_i.rate];
        step_q_o = q_tab[cfg_i.rate][cfg_i.depth];
        step_r_o = r_tab[cfg_i.rate][cfg_i.depth];
    end

endmodule

// File: rtl/ssc_sweep_core.sv
// Triangle sweep engine. It keeps a phase t in [0, H], a position
// p = floor(S*t/H) and the remainder acc = S*t mod H. Each cycle it moves
// t by one step, reversing at 0 and H, so p lands exactly on 0 and S at
// the turnarounds. Assumes S is even and H is even, so the center start
// (t = H/2, p = S/2) has a zero remainder.
module ssc_sweep_core #(
    parameter int P_W = 14,
    parameter int T_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic           start_i,
    input  logic           center_i,
    input  logic [P_W-1:0] span_i,
    input  logic [P_W-1:0] step_q_i,
    input  logic [T_W-1:0] step_r_i,
    input  logic [T_W-1:0] half_i,
    output logic [P_W-1:0] pos_o,
    output logic [T_W-1:0] phase_o
);

    logic [T_W-1:0] t_q, t_nx;
    logic [P_W-1:0] p_q, p_nx;
    logic [T_W-1:0] acc_q, acc_nx;
    logic           up_q, going_up;
    logic [T_W:0]   acc_sum;

    // Direction for this step: reverse at the ends of the phase range.
    always_comb begin
        going_up = up_q ? (t_q != half_i) : (t_q == '0);
    end

    // Next phase, position and remainder for one exact step.
    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, step_r_i};
        if (going_up) begin
            t_nx = t_q + 1'b1;
            if (acc_sum >= {1'b0, half_i}) begin
                acc_nx = T_W'(acc_sum - {1'b0, half_i});
                p_nx   = p_q + step_q_i + 1'b1;
            end else begin
                acc_nx = T_W'(acc_sum);
                p_nx   = p_q + step_q_i;
            end
        end else begin
            t_nx = t_q - 1'b1;
            if (acc_q < step_r_i) begin
                acc_nx = acc_q + half_i - step_r_i;
                p_nx   = p_q - step_q_i - 1'b1;
            end else begin
                acc_nx = acc_q - step_r_i;
                p_nx   = p_q - step_q_i;
            end
        end
    end

    // Sweep state: cleared when disabled, loaded on start, stepped otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            t_q   <= '0;
            p_q   <= '0;
            acc_q <= '0;
            up_q  <= 1'b0;
        end else if (start_i) begin
            t_q   <= center_i ? (half_i >> 1) : half_i;
            p_q   <= center_i ? (span_i >> 1) : span_i;
            acc_q <= '0;
            up_q  <= center_i;
        end else begin
            t_q   <= t_nx;
            p_q   <= p_nx;
            acc_q <= acc_nx;
            up_q  <= going_up;
        end
    end

    assign pos_o   = p_q;
    assign phase_o = t_q;

endmodule

// File: rtl/ssc_mod_gen.sv
// Top of the spread-spectrum triangle modulation generator. It captures the
// configuration at sweep start, looks up the exact step for the chosen span
// and rate, runs the triangle engine, and maps the position onto a signed
// offset: centered on zero for center spread, or at or below zero for down
// spread. Assumes the OFS_W signed range covers the largest span.
module ssc_mod_gen
    import ssc_pkg::*;
#(
    parameter int REF_HZ       = 25_000_000,
    parameter int RATE_SLOW_HZ = 32_000,
    parameter int RATE_FAST_HZ = 120_000,
    parameter int UNIT_LSB     = 256,
    parameter int NUM_CODES    = 5,
    parameter int OFS_W        = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic                    mode_i,
    input  logic [2:0]              depth_i,
    input  logic                    rate_i,
    output logic signed [OFS_W-1:0] offset_o,
    output logic                    turn_o
);

    localparam int HALF_SLOW = half_cycles(REF_HZ, RATE_SLOW_HZ);
    localparam int HALF_FAST = half_cycles(REF_HZ, RATE_FAST_HZ);
    localparam int HALF_MAX  = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
    localparam int SPAN_MAX  = full_span(UNIT_LSB, NUM_CODES - 1);
    localparam int P_W       = $clog2(SPAN_MAX + 1);
    localparam int T_W       = $clog2(HALF_MAX + 1);

    sweep_cfg_t     cfg_in, cfg_eff;
    logic           start, run_q;
    logic [P_W-1:0] span, step_q, pos;
    logic [T_W-1:0] step_r, half, phase;
    logic           center;

    // Pack the configuration pins into the shared type.
    always_comb begin
        cfg_in.mode  = spread_mode_e'(mode_i);
        cfg_in.rate  = sweep_rate_e'(rate_i);
        cfg_in.depth = depth_i;
    end

    ssc_cfg_hold #(
        .MAX_CODE (NUM_CODES - 1)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .cfg_i     (cfg_in),
        .cfg_eff_o (cfg_eff),
        .start_o   (start),
        .run_o     (run_q)
    );

    ssc_step_table #(
        .REF_HZ       (REF_HZ),
        .RATE_SLOW_HZ (RATE_SLOW_HZ),
        .RATE_FAST_HZ (RATE_FAST_HZ),
        .UNIT_LSB     (UNIT_LSB),
        .NUM_CODES    (NUM_CODES),
        .P_W          (P_W),
        .T_W          (T_W)
    ) u_table (
        .cfg_i    (cfg_eff),
        .span_o   (span),
        .step_q_o (step_q),
        .step_r_o (step_r),
        .half_o   (half)
    );

    assign center = (cfg_eff.mode == SPREAD_CENTER);

    ssc_sweep_core #(
        .P_W (P_W),
        .T_W (T_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .start_i  (start),
        .center_i (center),
        .span_i   (span),
        .step_q_i (step_q),
        .step_r_i (step_r),
        .half_i   (half),
        .pos_o    (pos),
        .phase_o  (phase)
    );

    // Map the position onto the signed offset and flag the extremes.
    always_comb begin
        logic signed [OFS_W-1:0] pos_s, base_s;
        pos_s  = OFS_W'(pos);
        base_s = center ? OFS_W'(span >> 1) : OFS_W'(span);
        offset_o = run_q ? (pos_s - base_s) : '0;
        turn_o   = run_q && ((phase == '0) || (phase == half));
    end

endmodule

// File: rtl/ssc_mod_gen_chk.sv
// Property checker for the modulation generator, bound to the top module.
// It observes the ports plus the captured span, half period and mode.
module ssc_mod_gen_chk #(
    parameter int OFS_W = 16,
    parameter int P_W   = 14,
    parameter int T_W   = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en_i,
    input logic                    run_q,
    input logic                    down_q,
    input logic [P_W-1:0]          span,
    input logic [T_W-1:0]          half,
    input logic signed [OFS_W-1:0] offset_o,
    input logic                    turn_o
);

    int off_v, span_v, lim_v;

    // Integer views used by the properties.
    always_comb begin
        off_v  = int'(offset_o);
        span_v = int'(span);
        lim_v  = (half != '0) ? (span_v / int'(half) + 1) : span_v;
    end

    // R2
    disable_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (offset_o == '0) && !turn_o);

    // R4
    center_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !down_q) |-> (off_v <= span_v / 2) && (off_v >= -(span_v / 2)));

    // R5
    down_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && down_q) |-> (off_v <= 0) && (off_v >= -span_v));

    // R8
    turn_extreme_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_o |-> (down_q ? (off_v == 0 || off_v == -span_v)
                           : (off_v == span_v / 2 || off_v == -(span_v / 2))));

    // R9
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> $stable(down_q) && $stable(span) && $stable(half));

    // R10
    step_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |->
            ((off_v - int'($past(offset_o)) <= lim_v) &&
             (int'($past(offset_o)) - off_v <= lim_v)));

endmodule

bind ssc_mod_gen ssc_mod_gen_chk #(
    .OFS_W (OFS_W),
    .P_W   (P_W),
    .T_W   (T_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .run_q    (run_q),
    .down_q   (!center),
    .span     (span),
    .half     (half),
    .offset_o (offset_o),
    .turn_o   (turn_o)
);

// File: tb/ssc_mod_gen_tb_top.sv
// Bench for the modulation generator: a behavioural model compared on every
// falling edge, plus directed checks on starts, extremes and turnarounds.
module ssc_mod_gen_tb_top;

    localparam int H_SLOW = 390;
    localparam int H_FAST = 104;
    localparam int UNIT   = 256;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en_i = 1'b0;
    logic               mode_i = 1'b0;
    logic [2:0]         depth_i = 3'd0;
    logic               rate_i = 1'b0;
    logic signed [15:0] offset_o;
    logic               turn_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int wd = 0;

    // model state
    bit m_run = 0, m_up = 0, m_down = 0;
    int m_s = 0, m_h = 1, m_t = 0;

    // observed statistics
    int st_max, st_min, st_last_turn, st_gap;
    int prev_off = 0;
    bit prev_run = 0;

    always #10 clk = ~clk;

    ssc_mod_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .mode_i   (mode_i),
        .depth_i  (depth_i),
        .rate_i   (rate_i),
        .offset_o (offset_o),
        .turn_o   (turn_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic int model_off();
        if (!m_run) return 0;
        return (m_s * m_t) / m_h - (m_down ? m_s : m_s / 2);
    endfunction

    // Reference model, advanced on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n || !en_i) begin
            m_run = 0;
        end else if (!m_run) begin
            int code;
            code   = (depth_i > 3'd4) ? 4 : int'(depth_i);
            m_run  = 1;
            m_down = mode_i;
            m_s    = (2 * UNIT) << code;
            m_h    = rate_i ? H_FAST : H_SLOW;
            m_t    = m_down ? m_h : m_h / 2;
            m_up   = !m_down;
        end else if (m_up) begin
            if (m_t == m_h) begin m_up = 0; m_t--; end
            else m_t++;
        end else begin
            if (m_t == 0) begin m_up = 1; m_t++; end
            else m_t--;
        end
        wd++;
        if (wd > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", wd);
            finish_run();
        end
    end

    // Per-cycle comparison and statistics, away from the active edge.
    always @(negedge clk) begin
        int off;
        off = int'(offset_o);
        cyc++;
        check("R8 offset profile", off, model_off());
        check("R8 turn flag", int'(turn_o), int'(m_run && (m_t == 0 || m_t == m_h)));
        if (m_run && prev_run) begin
            int lim, d;
            lim = m_s / m_h + 1;
            d   = off - prev_off;
            if (d < 0) d = -d;
            check("R10 step bound", int'(d <= lim), 1);
        end
        if (off > st_max) st_max = off;
        if (off < st_min) st_min = off;
        if (turn_o) begin
            if (st_last_turn >= 0) st_gap = cyc - st_last_turn;
            st_last_turn = cyc;
        end
        prev_off = off;
        prev_run = m_run;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_stats();
        st_max = -1000000;
        st_min = 1000000;
        st_last_turn = -1;
        st_gap = -1;
    endtask

    task automatic start_sweep(input logic md, input logic [2:0] dp, input logic rt);
        mode_i = md; depth_i = dp; rate_i = rt; en_i = 1'b1;
        clear_stats();
    endtask

    initial begin
        clear_stats();
        // R1: reset dominates even with enable high
        en_i = 1'b1;
        repeat (3) tick();
        check("R1 reset offset", int'(offset_o), 0);
        check("R1 reset turn", int'(turn_o), 0);
        en_i = 1'b0;
        tick();
        rst_n = 1'b1;
        repeat (2) tick();

        // R3/R4/R7: center, code 0, fast
        start_sweep(1'b0, 3'd0, 1'b1);
        tick();
        check("R3 center start value", int'(offset_o), 0);
        tick();
        check("R3 center rises first", int'(offset_o > 0), 1);
        repeat (3 * 2 * H_FAST) tick();
        check("R4 center max", st_max, UNIT);
        check("R4 center min", st_min, -UNIT);
        check("R7 fast half period", st_gap, H_FAST);

        // R9: configuration changes while running are ignored
        clear_stats();
        mode_i = 1'b1; depth_i = 3'd4; rate_i = 1'b0;
        repeat (300) tick();
        check("R9 max unchanged", st_max, UNIT);
        check("R9 min unchanged", st_min, -UNIT);
        check("R9 gap unchanged", st_gap, H_FAST);

        // R2: disable forces zero at the next edge
        en_i = 1'b0;
        tick();
        check("R2 offset zero", int'(offset_o), 0);
        check("R2 turn low", int'(turn_o), 0);
        repeat (5) tick();
        check("R2 stays zero", int'(offset_o), 0);

        // R5: down, code 2, fast
        start_sweep(1'b1, 3'd2, 1'b1);
        tick();
        check("R5 down start value", int'(offset_o), 0);
        check("R5 down start turn", int'(turn_o), 1);
        tick();
        check("R5 down falls first", int'(offset_o < 0), 1);
        repeat (2 * 2 * H_FAST + 10) tick();
        check("R5 down max", st_max, 0);
        check("R5 down min", st_min, -2 * (UNIT << 2));
        en_i = 1'b0;
        repeat (2) tick();

        // R6: code 7 saturates to code 4
        start_sweep(1'b0, 3'd7, 1'b1);
        repeat (2 * 2 * H_FAST + 10) tick();
        check("R6 saturated max", st_max, UNIT << 4);
        check("R6 saturated min", st_min, -(UNIT << 4));
        en_i = 1'b0;
        repeat (2) tick();

        // R7: slow rate, center code 1
        start_sweep(1'b0, 3'd1, 1'b0);
        repeat (2 * 2 * H_SLOW + 10) tick();
        check("R7 slow half period", st_gap, H_SLOW);
        check("R4 code1 max", st_max, UNIT << 1);
        check("R4 code1 min", st_min, -(UNIT << 1));
        en_i = 1'b0;
        repeat (3) tick();

        finish_run();
    end

endmodule